// File: doc/BRIEF.md
# Field-Counted General-Purpose Output Toggler

This block produces a bank of general-purpose output levels for an image-sensor timing path. Every output owns a small set of toggle slots, each placed at a line and pixel position inside the video field. A line strobe and a field strobe drive shared position counters. Each output has its own mode code, which decides when its slots may act. A slot placed at a position flips that output's level when the counters reach the position.

The modes are:
- off: the output stays at its idle level.
- one-shot: the output is active in the single field after a trigger.
- looping: after a trigger, the output is active in every field until the mode changes.
- counted: after a trigger, the output is active for a programmed number of fields, tracked by a per-output field counter.

A trigger that arrives in the middle of a field waits for the next field strobe before it takes effect. Each field strobe puts every output back to its idle level. Outputs are grouped in neighbouring pairs. Each pair can be passed through a four-entry lookup that maps the two raw levels to the two final levels.

Top module: `gp_field_toggler`

## Requirements
- R1: The pixel counter is 0 in the cycle after a line or field strobe is sampled, and increments by one each cycle after that. The line counter is 0 after a field strobe and increments on each line strobe. An armed slot at line L, pixel P inverts its output on the clock edge that ends the cycle in which the counters show (L, P).
- R2: Each output has NUM_TOG slots. Slot k of output j is enabled by bit j*NUM_TOG+k of the enable vector. A disabled slot never changes the output.
- R3: Mode code 0, and the unused codes 4 to 7, disable an output. A trigger sent to a disabled output has no effect. A field strobe seen while the code is disabled leaves that output inactive for the field that follows.
- R4: With mode code 1, a trigger makes the output active in exactly the next field. At the field strobe after that, the output becomes inactive unless another trigger arrived in the meantime.
- R5: With mode code 2, a trigger makes the output active from the next field onward, in every field. This continues until a field strobe is seen while the code is something else.
- R6: With mode code 3, a trigger makes the output active for rep_fields consecutive fields, counted once per field strobe; a count of 0 acts as 1. The output is then inactive until the next trigger.
- R7: Activation happens only at a field strobe. A trigger arms the output at the first field strobe that comes after the cycle in which the trigger is sampled. A trigger sampled in the same cycle as a field strobe therefore waits for the following strobe.
- R8: On every field strobe, each output's raw level is reloaded with its idle polarity bit.
- R9: A pair p with its lookup enabled drives outputs 2p+1 and 2p from lookup entry i = {raw[2p+1], raw[2p]}. Entry i sits at bits [p*8+2i+1 : p*8+2i], and its high bit goes to output 2p+1. With the lookup off, the raw levels pass straight through.
- R10: While reset is low, and after it, every raw level equals its idle polarity and no trigger is pending. The outputs show the lookup of those idle levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst_n | input | 1 | asynchronous active-low reset |
| hd_i | input | 1 | line-start strobe, one cycle |
| vd_i | input | 1 | field-start strobe, one cycle |
| trig_i | input | NUM_OUT (8) | per-output trigger strobe |
| mode_i | input | 3*NUM_OUT (24) | per-output mode code, output j at bits [3j+2:3j] |
| idle_pol_i | input | NUM_OUT (8) | per-output idle level |
| tog_en_i | input | NUM_OUT*NUM_TOG (32) | slot enables |
| tog_line_i | input | NUM_OUT*NUM_TOG*POS_W (416) | slot line positions |
| tog_pix_i | input | NUM_OUT*NUM_TOG*POS_W (416) | slot pixel positions |
| rep_fields_i | input | NUM_OUT*FLD_W (32) | field count for mode 3 |
| lut_en_i | input | NUM_OUT/2 (4) | per-pair lookup enable |
| lut_i | input | 8*NUM_OUT/2 (32) | per-pair lookup entries |
| gp_o | output | NUM_OUT (8) | final output levels |

## Verification
The counters register the strobes, so a slot at (L, P) flips the raw level one edge after the counters reach it. The lookup is combinational, so gp_o shows that flip right after that edge. Arming, disarming and the idle reload all take effect on the field-strobe edge itself. The bench therefore computes, from the cycle index c within each field, the expected level after edge c. It compares that level after every single edge of the field, so any output that changes one cycle early or late is caught. Reset values are checked while reset is still held, because they do not depend on a clock edge.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
   localparam int MODE_W      = 3;
   localparam int PAIR_IN     = 2;
   localparam int PAIR_LUT_W  = PAIR_IN * (1 << PAIR_IN);

   typedef enum logic [MODE_W-1:0] {
      MODE_OFF   = 3'd0,
      MODE_ONCE  = 3'd1,
      MODE_LOOP  = 3'd2,
      MODE_COUNT = 3'd3
   } gp_mode_e;

   function automatic logic mode_live(input logic [MODE_W-1:0] m);
      return (m == MODE_ONCE) || (m == MODE_LOOP) || (m == MODE_COUNT);
   endfunction
endpackage

// File: rtl/gpt_pos_count.sv
module gpt_pos_count #(
   parameter int POS_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hd_i,
   input  logic             vd_i,
   output logic [POS_W-1:0] line_o,
   output logic [POS_W-1:0] pix_o
);
   localparam logic [POS_W-1:0] POS_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_o <= '0;
         pix_o  <= '0;
      end else if (vd_i) begin
         line_o <= '0;
         pix_o  <= '0;
      end else if (hd_i) begin
         pix_o  <= '0;
         if (line_o != POS_MAX) line_o <= line_o + 1'b1;
      end else if (pix_o != POS_MAX) begin
         pix_o  <= pix_o + 1'b1;
      end
   end
endmodule

// File: rtl/gpt_chan.sv
module gpt_chan
   import gpt_pkg::*;
#(
   parameter int NUM_TOG = 4,
   parameter int POS_W   = 13,
   parameter int FLD_W   = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     vd_i,
   input  logic                     trig_i,
   input  logic [MODE_W-1:0]        mode_i,
   input  logic                     idle_i,
   input  logic [NUM_TOG-1:0]       tog_en_i,
   input  logic [NUM_TOG*POS_W-1:0] tog_line_i,
   input  logic [NUM_TOG*POS_W-1:0] tog_pix_i,
   input  logic [FLD_W-1:0]         rep_i,
   input  logic [POS_W-1:0]         line_i,
   input  logic [POS_W-1:0]         pix_i,
   output logic                     raw_o,
   output logic                     act_o,
   output logic                     pend_o
);
   logic             hit;
   logic             live;
   logic [FLD_W-1:0] fld_q;

   assign live = mode_live(mode_i);

   always_comb begin
      hit = 1'b0;
      for (int k = 0; k < NUM_TOG; k++) begin
         if (tog_en_i[k] &&
             line_i == tog_line_i[k*POS_W +: POS_W] &&
             pix_i  == tog_pix_i[k*POS_W +: POS_W])
            hit = 1'b1;
      end
   end

   // trigger latch: set by a strobe, consumed by the next field start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend_o <= 1'b0;
      else if (!live)   pend_o <= 1'b0;
      else if (trig_i)  pend_o <= 1'b1;
      else if (vd_i)    pend_o <= 1'b0;
   end

   // field-level activity and field count
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_o <= 1'b0;
         fld_q <= '0;
      end else if (vd_i) begin
         if (!live) begin
            act_o <= 1'b0;
         end else if (pend_o) begin
            act_o <= 1'b1;
            fld_q <= FLD_W'(1);
         end else if (act_o) begin
            case (gp_mode_e'(mode_i))
               MODE_LOOP:  act_o <= 1'b1;
               MODE_COUNT: begin
                  if (fld_q >= rep_i) act_o <= 1'b0;
                  else                fld_q <= fld_q + 1'b1;
               end
               default:    act_o <= 1'b0;
            endcase
         end
      end
   end

   // raw level: reload at field start, flip on a slot hit while active
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             raw_o <= idle_i;
      else if (vd_i)          raw_o <= idle_i;
      else if (act_o && hit)  raw_o <= ~raw_o;
   end
endmodule

// File: rtl/gpt_pair_lut.sv
module gpt_pair_lut
   import gpt_pkg::*;
(
   input  logic [PAIR_IN-1:0]    raw_i,
   input  logic                  en_i,
   input  logic [PAIR_LUT_W-1:0] lut_i,
   output logic [PAIR_IN-1:0]    out_o
);
   always_comb begin
      if (en_i) out_o = lut_i[{raw_i, 1'b0} +: PAIR_IN];
      else      out_o = raw_i;
   end
endmodule

// File: rtl/gp_field_toggler.sv
module gp_field_toggler
   import gpt_pkg::*;
#(
   parameter int NUM_OUT  = 8,
   parameter int NUM_TOG  = 4,
   parameter int POS_W    = 13,
   parameter int FLD_W    = 4,
   localparam int NUM_PAIR = NUM_OUT / PAIR_IN,
   localparam int SLOT_N   = NUM_OUT * NUM_TOG
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           hd_i,
   input  logic                           vd_i,
   input  logic [NUM_OUT-1:0]             trig_i,
   input  logic [NUM_OUT*MODE_W-1:0]      mode_i,
   input  logic [NUM_OUT-1:0]             idle_pol_i,
   input  logic [SLOT_N-1:0]              tog_en_i,
   input  logic [SLOT_N*POS_W-1:0]        tog_line_i,
   input  logic [SLOT_N*POS_W-1:0]        tog_pix_i,
   input  logic [NUM_OUT*FLD_W-1:0]       rep_fields_i,
   input  logic [NUM_PAIR-1:0]            lut_en_i,
   input  logic [NUM_PAIR*PAIR_LUT_W-1:0] lut_i,
   output logic [NUM_OUT-1:0]             gp_o
);
   localparam int CH_POS_W = NUM_TOG * POS_W;

   if (NUM_OUT < PAIR_IN || (NUM_OUT % PAIR_IN) != 0) begin : g_bad_num_out
      $error("NUM_OUT must be a positive even count");
   end
   if (NUM_TOG < 1) begin : g_bad_num_tog
      $error("NUM_TOG must be at least 1");
   end
   if (POS_W < 2 || FLD_W < 1) begin : g_bad_width
      $error("POS_W must be >= 2 and FLD_W >= 1");
   end

   logic [POS_W-1:0]   line_w;
   logic [POS_W-1:0]   pix_w;
   logic [NUM_OUT-1:0] raw_w;
   logic [NUM_OUT-1:0] act_w;
   logic [NUM_OUT-1:0] pend_w;

   gpt_pos_count #(.POS_W(POS_W)) pos_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .hd_i   (hd_i),
      .vd_i   (vd_i),
      .line_o (line_w),
      .pix_o  (pix_w)
   );

   for (genvar j = 0; j < NUM_OUT; j++) begin : g_chan
      gpt_chan #(
         .NUM_TOG (NUM_TOG),
         .POS_W   (POS_W),
         .FLD_W   (FLD_W)
      ) chan_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .vd_i       (vd_i),
         .trig_i     (trig_i[j]),
         .mode_i     (mode_i[j*MODE_W +: MODE_W]),
         .idle_i     (idle_pol_i[j]),
         .tog_en_i   (tog_en_i[j*NUM_TOG +: NUM_TOG]),
         .tog_line_i (tog_line_i[j*CH_POS_W +: CH_POS_W]),
         .tog_pix_i  (tog_pix_i[j*CH_POS_W +: CH_POS_W]),
         .rep_i      (rep_fields_i[j*FLD_W +: FLD_W]),
         .line_i     (line_w),
         .pix_i      (pix_w),
         .raw_o      (raw_w[j]),
         .act_o      (act_w[j]),
         .pend_o     (pend_w[j])
      );
   end

   for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
      gpt_pair_lut pair_i (
         .raw_i (raw_w[p*PAIR_IN +: PAIR_IN]),
         .en_i  (lut_en_i[p]),
         .lut_i (lut_i[p*PAIR_LUT_W +: PAIR_LUT_W]),
         .out_o (gp_o[p*PAIR_IN +: PAIR_IN])
      );
   end
endmodule

// File: rtl/gp_field_toggler_chk.sv
module gp_field_toggler_chk
   import gpt_pkg::*;
#(
   parameter int NUM_OUT = 8
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      vd_i,
   input logic [NUM_OUT*MODE_W-1:0] mode_i,
   input logic [NUM_OUT-1:0]        idle_i,
   input logic [NUM_OUT-1:0]        raw_i,
   input logic [NUM_OUT-1:0]        act_i,
   input logic [NUM_OUT-1:0]        pend_i
);
   logic [NUM_OUT-1:0] live_m;
   logic [NUM_OUT-1:0] once_m;
   logic [NUM_OUT-1:0] loop_m;

   always_comb begin
      for (int j = 0; j < NUM_OUT; j++) begin
         live_m[j] = mode_live(mode_i[j*MODE_W +: MODE_W]);
         once_m[j] = (mode_i[j*MODE_W +: MODE_W] == MODE_ONCE);
         loop_m[j] = (mode_i[j*MODE_W +: MODE_W] == MODE_LOOP);
      end
   end

   AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!vd_i && act_i == '0) |=> $stable(raw_i)); // R1
   AST_DISABLED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      vd_i |=> (act_i & ~$past(live_m)) == '0); // R3
   AST_ONCE_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      vd_i |=> (act_i & $past(once_m & ~pend_i)) == '0); // R4
   AST_LOOP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      vd_i |=> ($past(loop_m & act_i) & ~act_i) == '0); // R5
   AST_RISE_ON_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      !vd_i |=> (act_i & ~$past(act_i)) == '0); // R7
   AST_FIELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      vd_i |=> raw_i == $past(idle_i)); // R8
endmodule

bind gp_field_toggler gp_field_toggler_chk #(.NUM_OUT(NUM_OUT)) chk_i (
   .clk    (clk),
   .rst_n  (rst_n),
   .vd_i   (vd_i),
   .mode_i (mode_i),
   .idle_i (idle_pol_i),
   .raw_i  (raw_w),
   .act_i  (act_w),
   .pend_i (pend_w)
);

// File: tb/gp_field_toggler_tb_top.sv
module gp_field_toggler_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NO         = 8;
   localparam int NT         = 4;
   localparam int PW         = 13;
   localparam int FW         = 4;
   localparam int NP         = NO / 2;
   localparam int LINE_LEN   = 16;
   localparam int FIELD_LEN  = 64;
   localparam int N_VEC      = 12;
   localparam logic [23:0] CFG_A = 24'h05B489;
   localparam logic [23:0] CFG_B = 24'hA5B009;
   localparam logic [7:0]  IDLE  = 8'hA5;

   typedef struct packed {
      logic [23:0] cfg;
      logic [7:0]  trig;
      logic [7:0]  cyc;
      logic [7:0]  act;
      logic [3:0]  kind;
   } vec_t;

   // mode codes per output (A): 0,1 one-shot; 2,3 looping; 4,5 counted; 6 one-shot; 7 off
   localparam vec_t VECS [N_VEC] = '{
      '{CFG_A, 8'h00, 8'd0,  8'h00, 4'd0},
      '{CFG_A, 8'hFF, 8'd20, 8'h00, 4'd1},
      '{CFG_A, 8'h00, 8'd0,  8'h7F, 4'd2},
      '{CFG_A, 8'h01, 8'd20, 8'h3C, 4'd3},
      '{CFG_A, 8'h01, 8'd40, 8'h0D, 4'd4},
      '{CFG_A, 8'h10, 8'd20, 8'h0D, 4'd4},
      '{CFG_A, 8'h00, 8'd0,  8'h1C, 4'd3},
      '{CFG_A, 8'h00, 8'd0,  8'h1C, 4'd3},
      '{CFG_A, 8'h00, 8'd0,  8'h0C, 4'd3},
      '{CFG_B, 8'h02, 8'd0,  8'h00, 4'd5},
      '{CFG_B, 8'h80, 8'd30, 8'h02, 4'd6},
      '{CFG_B, 8'h00, 8'd0,  8'h00, 4'd7}
   };

   logic               clk = 1'b0;
   logic               rst_n;
   logic               hd_i, vd_i;
   logic [NO-1:0]      trig_i;
   logic [NO*3-1:0]    mode_i;
   logic [NO-1:0]      idle_pol_i;
   logic [NO*NT-1:0]   tog_en_i;
   logic [NO*NT*PW-1:0] tog_line_i, tog_pix_i;
   logic [NO*FW-1:0]   rep_fields_i;
   logic [NP-1:0]      lut_en_i;
   logic [NP*8-1:0]    lut_i;
   logic [NO-1:0]      gp_o;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   gp_field_toggler #(.NUM_OUT(NO), .NUM_TOG(NT), .POS_W(PW), .FLD_W(FW)) dut_i (
      .clk(clk), .rst_n(rst_n), .hd_i(hd_i), .vd_i(vd_i), .trig_i(trig_i),
      .mode_i(mode_i), .idle_pol_i(idle_pol_i), .tog_en_i(tog_en_i),
      .tog_line_i(tog_line_i), .tog_pix_i(tog_pix_i), .rep_fields_i(rep_fields_i),
      .lut_en_i(lut_en_i), .lut_i(lut_i), .gp_o(gp_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   function automatic string kind_str(input logic [3:0] k);
      case (k)
         4'd0:    return "R10 R8 quiet after reset";
         4'd1:    return "R7 R3 trigger held to field start";
         4'd2:    return "R4 R5 R6 R2 R9 R1 first armed field";
         4'd3:    return "R6 R5 R1 repeated fields";
         4'd4:    return "R4 one-shot retrigger";
         4'd5:    return "R5 R7 mode off and field-start trigger";
         4'd6:    return "R7 trigger from field-start cycle";
         default: return "R3 reserved code ignored";
      endcase
   endfunction

   // R9: pair lookup, entry {hi,lo} index, high bit to odd output
   function automatic logic [7:0] apply_lut(input logic [7:0] r);
      logic [7:0] o = r;
      for (int p = 0; p < NP; p++) begin
         int idx = {r[2*p+1], r[2*p]};
         if (lut_en_i[p]) o[2*p +: 2] = lut_i[p*8 + 2*idx +: 2];
      end
      return o;
   endfunction

   // R1/R2/R8: level after edge c of a field; slot k of output j sits at line k, pixel j+2
   function automatic logic [7:0] exp_gpo(input logic [7:0] act, input int c);
      logic [7:0] r = IDLE;
      for (int j = 0; j < NO; j++)
         for (int k = 0; k < NT; k++)
            if (act[j] && tog_en_i[j*NT+k] && (LINE_LEN*k + j + 3 <= c)) r[j] = ~r[j];
      return apply_lut(r);
   endfunction

   task automatic run_field(input logic [23:0] cfg, input logic [7:0] trig,
                            input int cyc, input logic [7:0] act, input string tag);
      for (int c = 0; c < FIELD_LEN; c++) begin
         mode_i = cfg;
         vd_i   = (c == 0);
         hd_i   = (c % LINE_LEN == 0);
         trig_i = (c == cyc) ? trig : '0;
         @(posedge clk);
         #1;
         chk($sformatf("%s cyc %0d", tag, c), gp_o, exp_gpo(act, c));
      end
      vd_i = 1'b0; hd_i = 1'b0; trig_i = '0;
   endtask

   initial begin
      rst_n = 1'b0; hd_i = 1'b0; vd_i = 1'b0; trig_i = '0;
      mode_i = CFG_A; idle_pol_i = IDLE;
      lut_en_i = 4'b1100;
      lut_i = {8'hE8, 8'hD8, 8'h00, 8'h00};
      for (int j = 0; j < NO; j++) begin
         rep_fields_i[j*FW +: FW] = FW'(2);
         for (int k = 0; k < NT; k++) begin
            tog_line_i[(j*NT+k)*PW +: PW] = PW'(k);
            tog_pix_i[(j*NT+k)*PW +: PW]  = PW'(j + 2);
            tog_en_i[j*NT+k] = (j == 6) ? (k % 2 == 0) : 1'b1;
         end
      end
      repeat (3) @(posedge clk);
      #1;
      chk("R10 reset level", gp_o, 8'h95);
      chk("R9 R10 reset lookup", gp_o, apply_lut(IDLE));
      rst_n = 1'b1;

      for (int i = 0; i < N_VEC; i++)
         run_field(VECS[i].cfg, VECS[i].trig, int'(VECS[i].cyc), VECS[i].act,
                   $sformatf("%s field %0d", kind_str(VECS[i].kind), i));

      // pending trigger lost through reset
      run_field(CFG_A, 8'h01, 20, 8'h00, "R4 trigger before reset");
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      chk("R10 mid-run reset", gp_o, 8'h95);
      rst_n = 1'b1;
      run_field(CFG_A, 8'h00, 0, 8'h00, "R10 pending cleared by reset");
      run_field(CFG_A, 8'h01, 20, 8'h00, "R7 rearm after reset");
      run_field(CFG_A, 8'h00, 0, 8'h01, "R4 R1 one-shot after reset");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule